// File: doc/BRIEF.md
# Elapsed-Time Counter with Alarm Compare

This block is the timekeeping core of a real-time clock. A 48-bit counter advances by one on every cycle in which the tick-enable input is high. The tick enable is meant to pulse at 32768 Hz, so counter bits [47:15] hold whole seconds (a 33-bit value) and bits [14:0] hold the sub-second fraction. Software reaches the counter through three 16-bit slices on a simple 16-bit register bus. Reads return live values and are not latched. Software therefore reads all three slices twice and repeats until both passes agree.

A second 48-bit value, laid out in the same three slices, is the alarm compare. On a tick cycle, the block compares the counter value that the tick produces with the compare value over all 48 bits. When they are equal, a sticky status bit is set. Software clears that bit by writing a one to it. The level interrupt output is the status bit gated by an enable bit. A match does not stop the counter.

The bus is address-decoded with a write strobe. Read data is a combinational function of the address. Each write updates one 16-bit slice on the clock edge.

Top module: `rtc_elapsed_core`

## Requirements
- R1: After reset, every counter slice, every compare slice, the enable bit and the status bit read zero, and irq_o is low.
- R2: Register map on addr_i. Counter slices sit at 0x00 (bits 15:0), 0x02 (bits 31:16) and 0x04 (bits 47:32). Compare slices sit at 0x08, 0x0a and 0x0c with the same bit ranges. The interrupt enable is bit 0 at 0x1c. The status is bit 0 at 0x1e. Unused bits and unmapped addresses read 0. A write with req_i=1 and we_i=1 loads only the addressed slice or bit.
- R3: The counter advances by exactly one per clock cycle with tick_en_i=1. Without a tick and without a write, it holds its value.
- R4: The increment carries across slice boundaries. For example, 0x0000_FFFF_FFFF becomes 0x0001_0000_0000.
- R5: The counter wraps from all ones to zero.
- R6: A slice write in a tick cycle takes priority over the increment for that slice only. The other slices still take the incremented value, including any carry out of the overwritten slice.
- R7: Seconds layout. Loading seconds S as low = (S<<15), mid = (S>>1) and high = (S>>17), each truncated to 16 bits, reads back as S = {high, mid, low[15]}. After 32768 ticks the value reads back as S+1.
- R8: On a tick cycle, the status bit is set when the counter value written at that edge equals the compare value over all 48 bits. An equal value reached by a bus write without a tick does not set it.
- R9: A match does not stop the counter, and the status bit stays set while ticks continue.
- R10: Writing 1 to bit 0 at 0x1e clears the status bit. Writing 0 there leaves it unchanged.
- R11: irq_o equals the status bit AND the enable bit.
- R12: When a match and a clear fall in the same cycle, the match wins and the status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | Counter advance enable, one cycle per 32.768 kHz tick |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, with req_i |
| addr_i | input | 5 | Byte address of a 16-bit register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
The hardest situation to reach from the ports is a bus write that lands in the same cycle as a tick. This covers two cases: a slice overwritten while the other slices take a carry, and a status clear that collides with a match. The bench reaches both with a write task that also raises tick_en_i for exactly that cycle. Before the write, it preloads the counter to a value just below a slice boundary or just below the compare value. Long-carry behaviour is reached without waiting, by writing the slices to all-ones patterns before a single tick.

// File: rtl/rtc_elapsed_pkg.sv
package rtc_elapsed_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BUS_W  = 16;

  localparam logic [ADDR_W-1:0] OFF_CNT  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_CMP  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 5'h1c;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h1e;

  // 16-bit registers sit on even byte addresses
  function automatic logic [ADDR_W-1:0] slice_addr(logic [ADDR_W-1:0] base, int unsigned idx);
    return base + ADDR_W'(2 * idx);
  endfunction
endpackage

// File: rtl/rtc_slice_counter.sv
module rtc_slice_counter #(
  parameter int unsigned CNT_W   = 48,
  parameter int unsigned SLICE_W = 16,
  localparam int unsigned N_SLICE = CNT_W / SLICE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [N_SLICE-1:0] wr_i,
  input  logic [SLICE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]   cnt_q_o,
  output logic [CNT_W-1:0]   cnt_d_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_inc;
  logic [SLICE_W-1:0] slc_d [N_SLICE];

  assign cnt_inc = cnt_q + CNT_W'(1);

  for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
    always_comb begin
      if (wr_i[i])     slc_d[i] = wdata_i;
      else if (tick_i) slc_d[i] = cnt_inc[i*SLICE_W +: SLICE_W];
      else             slc_d[i] = cnt_q[i*SLICE_W +: SLICE_W];
    end
    assign cnt_d_o[i*SLICE_W +: SLICE_W] = slc_d[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d_o;
  end

  assign cnt_q_o = cnt_q;
endmodule

// File: rtl/rtc_cmp_regs.sv
module rtc_cmp_regs #(
  parameter int unsigned CNT_W   = 48,
  parameter int unsigned SLICE_W = 16,
  localparam int unsigned N_SLICE = CNT_W / SLICE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLICE-1:0] wr_i,
  input  logic [SLICE_W-1:0] wdata_i,
  output logic [CNT_W-1:0]   cmp_o
);
  logic [SLICE_W-1:0] slc_q [N_SLICE];

  for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      slc_q[i] <= '0;
      else if (wr_i[i]) slc_q[i] <= wdata_i;
    end
    assign cmp_o[i*SLICE_W +: SLICE_W] = slc_q[i];
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic stat_wr_i,
  input  logic ien_wr_i,
  input  logic wbit_i,
  output logic status_o,
  output logic ien_o,
  output logic irq_o
);
  logic status_q;
  logic ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      ien_q    <= 1'b0;
    end else begin
      // set beats write-one-to-clear
      if (match_i)                  status_q <= 1'b1;
      else if (stat_wr_i && wbit_i) status_q <= 1'b0;
      if (ien_wr_i)                 ien_q    <= wbit_i;
    end
  end

  assign status_o = status_q;
  assign ien_o    = ien_q;
  assign irq_o    = status_q & ien_q;
endmodule

// File: rtl/rtc_elapsed_core.sv
module rtc_elapsed_core
  import rtc_elapsed_pkg::*;
#(
  parameter int unsigned CNT_W   = 48,
  parameter int unsigned SLICE_W = 16,
  localparam int unsigned N_SLICE = CNT_W / SLICE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic               wr_en;
  logic [N_SLICE-1:0] cnt_wr;
  logic [N_SLICE-1:0] cmp_wr;
  logic               ien_wr;
  logic               stat_wr;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_d;
  logic [CNT_W-1:0]   cmp_q;
  logic               alarm_hit;
  logic               status_q;
  logic               irq_en_q;

  assign wr_en = req_i & we_i;

  for (genvar i = 0; i < N_SLICE; i++) begin : g_dec
    assign cnt_wr[i] = wr_en && (addr_i == slice_addr(OFF_CNT, i));
    assign cmp_wr[i] = wr_en && (addr_i == slice_addr(OFF_CMP, i));
  end
  assign ien_wr  = wr_en && (addr_i == OFF_IEN);
  assign stat_wr = wr_en && (addr_i == OFF_STAT);

  rtc_slice_counter #(.CNT_W(CNT_W), .SLICE_W(SLICE_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_en_i),
    .wr_i    (cnt_wr),
    .wdata_i (wdata_i[SLICE_W-1:0]),
    .cnt_q_o (cnt_q),
    .cnt_d_o (cnt_d)
  );

  rtc_cmp_regs #(.CNT_W(CNT_W), .SLICE_W(SLICE_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cmp_wr),
    .wdata_i (wdata_i[SLICE_W-1:0]),
    .cmp_o   (cmp_q)
  );

  // compare the value this tick produces
  assign alarm_hit = tick_en_i && (cnt_d == cmp_q);

  rtc_irq_ctrl u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .match_i   (alarm_hit),
    .stat_wr_i (stat_wr),
    .ien_wr_i  (ien_wr),
    .wbit_i    (wdata_i[0]),
    .status_o  (status_q),
    .ien_o     (irq_en_q),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_SLICE; i++) begin
      if (addr_i == slice_addr(OFF_CNT, i))
        rdata_o[SLICE_W-1:0] = cnt_q[i*SLICE_W +: SLICE_W];
      if (addr_i == slice_addr(OFF_CMP, i))
        rdata_o[SLICE_W-1:0] = cmp_q[i*SLICE_W +: SLICE_W];
    end
    if (addr_i == OFF_IEN)  rdata_o[0] = irq_en_q;
    if (addr_i == OFF_STAT) rdata_o[0] = status_q;
  end
endmodule

// File: rtl/rtc_elapsed_core_chk.sv
module rtc_elapsed_core_chk
  import rtc_elapsed_pkg::*;
#(
  parameter int unsigned CNT_W = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_en_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wbit_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              status_q,
  input logic              irq_en_q
);
  logic wr_any;
  logic clr_wr;
  assign wr_any = req_i && we_i;
  assign clr_wr = wr_any && (addr_i == OFF_STAT) && wbit_i;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i && !wr_any |=> $stable(cnt_q));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_i && !wr_any |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q && !clr_wr |=> status_q);

  p_no_set_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_q && !tick_en_i |=> !status_q);

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !tick_en_i |=> !status_q);

  p_irq_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_q |-> !irq_o);
endmodule

bind rtc_elapsed_core rtc_elapsed_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_en_i (tick_en_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wbit_i    (wdata_i[0]),
  .irq_o     (irq_o),
  .cnt_q     (cnt_q),
  .status_q  (status_q),
  .irq_en_q  (irq_en_q)
);

// File: tb/rtc_elapsed_core_tb.sv
module rtc_elapsed_core_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_en_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  rtc_elapsed_core u_dut (
    .clk_i, .rst_ni, .tick_en_i, .req_i, .we_i,
    .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  // {addr, write data, expected read}
  localparam int N_VEC = 8;
  localparam logic [36:0] VEC [N_VEC] = '{
    {5'h00, 16'h1357, 16'h1357},
    {5'h02, 16'h2468, 16'h2468},
    {5'h04, 16'hC0DE, 16'hC0DE},
    {5'h08, 16'hA5A5, 16'hA5A5},
    {5'h0a, 16'h5A5A, 16'h5A5A},
    {5'h0c, 16'h0F0F, 16'h0F0F},
    {5'h1c, 16'hFFFF, 16'h0001},
    {5'h10, 16'hFFFF, 16'h0000}
  };

  task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d, logic t = 1'b0);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; tick_en_i = t;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; tick_en_i = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic ticks(int n);
    @(negedge clk_i);
    tick_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_en_i = 1'b0;
  endtask

  task automatic set_cnt(logic [47:0] v);
    wr(5'h00, v[15:0]); wr(5'h02, v[31:16]); wr(5'h04, v[47:32]);
  endtask

  task automatic get_cnt(output logic [47:0] v);
    logic [15:0] l, m, h;
    rd(5'h00, l); rd(5'h02, m); rd(5'h04, h);
    v = {h, m, l};
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=timeout exp=done");
      finish_run();
    end
  end

  initial begin
    logic [15:0] r;
    logic [47:0] c;
    logic [32:0] sec;
    logic [32:0] sec_rd;

    #7 rst_ni = 1'b1;

    // R1 reset state
    foreach (VEC[i]) begin
      rd(VEC[i][36:32], r);
      chk($sformatf("R1 reset addr %h", VEC[i][36:32]), 48'(r), 48'h0);
    end
    rd(5'h1e, r);
    chk("R1 status reset", 48'(r), 48'h0);
    chk("R1 irq reset", 48'(irq_o), 48'h0);

    // R2 register map table
    for (int i = 0; i < N_VEC; i++) wr(VEC[i][36:32], VEC[i][31:16]);
    for (int i = 0; i < N_VEC; i++) begin
      rd(VEC[i][36:32], r);
      chk($sformatf("R2 addr %h", VEC[i][36:32]), 48'(r), 48'(VEC[i][15:0]));
    end
    wr(5'h1c, 16'h0000);

    // R3 hold without tick, step with ticks
    set_cnt(48'h0000_0000_0100);
    repeat (5) @(negedge clk_i);
    get_cnt(c);
    chk("R3 hold", c, 48'h100);
    ticks(7);
    get_cnt(c);
    chk("R3 step", c, 48'h107);

    // R4 carry across slices
    set_cnt(48'h0000_FFFF_FFFF);
    ticks(1);
    get_cnt(c);
    chk("R4 carry", c, 48'h0001_0000_0000);

    // R5 wrap
    set_cnt(48'hFFFF_FFFF_FFFF);
    ticks(1);
    get_cnt(c);
    chk("R5 wrap", c, 48'h0);

    // R6 write beats increment for its slice only
    set_cnt(48'h0000_0000_0005);
    wr(5'h00, 16'h1234, 1'b1);
    get_cnt(c);
    chk("R6 low overwrite", c, 48'h0000_0000_1234);
    set_cnt(48'h0000_0000_FFFF);
    wr(5'h02, 16'h0100, 1'b1);
    get_cnt(c);
    chk("R6 mid overwrite", c, 48'h0000_0100_0000);

    // R7 seconds layout and one-second advance
    sec = 33'h1_2345_6789;
    wr(5'h00, 16'(sec << 15));
    wr(5'h02, 16'(sec >> 1));
    wr(5'h04, 16'(sec >> 17));
    get_cnt(c);
    sec_rd = {c[47:32], c[31:16], c[15]};
    chk("R7 seconds readback", 48'(sec_rd), 48'(sec));
    chk("R7 fraction zero", 48'(c[14:0]), 48'h0);
    ticks(32768);
    get_cnt(c);
    sec_rd = {c[47:32], c[31:16], c[15]};
    chk("R7 seconds plus one", 48'(sec_rd), 48'(sec + 33'd1));

    // R8 alarm only on tick
    wr(5'h1e, 16'h0001);
    wr(5'h08, 16'h0010); wr(5'h0a, 16'h0000); wr(5'h0c, 16'h0000);
    set_cnt(48'h10);
    rd(5'h1e, r);
    chk("R8 no match on write", 48'(r), 48'h0);
    set_cnt(48'h0E);
    ticks(1);
    rd(5'h1e, r);
    chk("R8 before match", 48'(r), 48'h0);
    ticks(1);
    rd(5'h1e, r);
    chk("R8 match sets", 48'(r), 48'h1);
    chk("R11 irq masked", 48'(irq_o), 48'h0);

    // R9 counter continues, status sticky
    ticks(3);
    get_cnt(c);
    chk("R9 count continues", c, 48'h13);
    rd(5'h1e, r);
    chk("R9 status sticky", 48'(r), 48'h1);

    // R10 write zero keeps status
    wr(5'h1e, 16'h0000);
    rd(5'h1e, r);
    chk("R10 write zero", 48'(r), 48'h1);

    // R11 enable gates irq
    wr(5'h1c, 16'h0001);
    chk("R11 irq asserted", 48'(irq_o), 48'h1);

    // R10 write one clears
    wr(5'h1e, 16'h0001);
    rd(5'h1e, r);
    chk("R10 clear", 48'(r), 48'h0);
    chk("R11 irq after clear", 48'(irq_o), 48'h0);

    // R12 match beats simultaneous clear
    set_cnt(48'h0F);
    wr(5'h1e, 16'h0001, 1'b1);
    rd(5'h1e, r);
    chk("R12 set wins", 48'(r), 48'h1);
    get_cnt(c);
    chk("R12 count", c, 48'h10);
    chk("R12 irq", 48'(irq_o), 48'h1);

    done = 1'b1;
    finish_run();
  end
endmodule